// File: doc/BRIEF.md
# Privileged Control Register File

This block keeps the supervisor-level and hypervisor-level control state of one hardware thread in a windowed RISC core. A 6-bit select code picks one register on each of two independent ports: a write port that commits on the rising clock edge and a read port whose data settles combinationally in the same cycle. Some registers apply per-register rules on the way in: the processor-state word keeps only its defined fields, the trap base address drops its low offset bits, and the trap-level register is clamped to the deepest level the core supports.

Five trap-save stacks (trap PC, trap next-PC, trap state, trap type and hypervisor trap state) are addressed implicitly through the current trap level, so software sees only the entry of the level it is running at. A write to the trap level also decides a trap-level-zero interrupt request. A packed translation-context word, built from fields spread across several registers, is offered both as a dedicated output for the address-translation logic and as a read-only select code. Select codes that name nothing, name unimplemented performance registers, or name a trap stack while the trap level is zero are flagged on the matching error output and leave all state untouched.

Top module: `priv_ctl_bank`

## Requirements
- R1: After reset the tick register (code 10) reads 0x8000000000000000, the hypervisor state (code 9) reads 0x800, the strand status (code 12) reads 0x50000, `tlz_irq` is 0 and every other register, including scratch and queue entries, reads 0.
- R2: A write to the processor-state word (code 0) stores only bits 1, 2, 3, 4, 7:6, 8, 9 and 11 of the data; all other bits read back as 0.
- R3: A write to the trap base address (code 3) stores the data with bits 14:0 cleared.
- R4: The trap PC (4), trap next-PC (5), trap state (6), trap type (7) and hypervisor trap state (8) each hold MAX_TL independent 64-bit entries; reads and writes reach the entry for trap level TL, so an entry written at one level is unchanged by writes at other levels.
- R5: A write to the trap level (code 1) stores the data clamped to MAX_TL (default 6).
- R6: On a trap-level write, `tlz_irq` becomes 1 on the next edge when hypervisor-state bit 0 is 1, bit 2 is 0 and the stored new level is 0; otherwise it becomes 0. Writes to any other code leave it unchanged.
- R7: The FP register state (code 11) stores data bits 2:0; a read with `rd_fx` low returns the stored value, with `rd_fx` high it returns the stored value ORed with 0x3.
- R8: The translation word (`xlat_word`, also read at code 17) holds hypervisor-state bit 2 at bit 0, hypervisor-state bit 5 at bit 1, processor-state bits 2 and 3 at bits 2 and 3, load/store control bits 3:2 at bits 5:4, partition ID (code 14, 8 bits) at 15:8, TL at 18:16, primary context (code 15, 16 bits) at 47:32 and secondary context (code 16, 16 bits) at 63:48, other bits 0; load/store control is code 13.
- R9: Eight scratch registers (codes 32 to 39) and eight queue registers (codes 40 to 47: head/tail pairs for processor mondo, device mondo, resumable error, non-resumable error) are independently readable and writable at 64 bits.
- R10: Codes 18 and 19 (performance control and counter) and all codes not listed in R1 to R9 raise the matching error output, read as 0, and a write to them changes no state; a write to code 17 also raises `wr_err`.
- R11: While TL is 0, any access to codes 4 to 8 raises the matching error output, reads as 0, and a write stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 6 | Write select code |
| wr_data | input | 64 | Write data |
| wr_err | output | 1 | Write to an invalid code or unreachable stack entry (combinational) |
| rd_sel | input | 6 | Read select code |
| rd_fx | input | 1 | Read with side effects (FP register state dirty bits) |
| rd_data | output | 64 | Read data (combinational) |
| rd_err | output | 1 | Read of an invalid code or unreachable stack entry |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |
| xlat_word | output | 64 | Packed translation-context word |

## Verification
The bench targets the trap stacks with an interleaved walk across levels 1, 2 and the top level, so a design that indexed by TL instead of TL-1, or shared one entry across levels, would return a neighbour's value. It writes all ones to the processor-state word and a dense pattern to the trap base so a wrong mask or an off-by-one clear width shows as stray bits, and it drives the trap level above its ceiling to catch a missing clamp. The interrupt rule is exercised with each enabling condition removed in turn, which catches a design that ignores the hypervisor bit or lets unrelated writes clear the request; rejected writes at TL 0 and to unimplemented codes are followed by reads that would expose a leaked store.

// File: rtl/priv_pkg.sv
package priv_pkg;
   localparam int SW = 6;
   localparam int DW = 64;

   localparam logic [SW-1:0] SEL_PSTATE  = 6'd0;
   localparam logic [SW-1:0] SEL_TL      = 6'd1;
   localparam logic [SW-1:0] SEL_PIL     = 6'd2;
   localparam logic [SW-1:0] SEL_TBA     = 6'd3;
   localparam logic [SW-1:0] SEL_TPC     = 6'd4;
   localparam logic [SW-1:0] SEL_HTSTATE = 6'd8;
   localparam logic [SW-1:0] SEL_HPSTATE = 6'd9;
   localparam logic [SW-1:0] SEL_TICK    = 6'd10;
   localparam logic [SW-1:0] SEL_FPRS    = 6'd11;
   localparam logic [SW-1:0] SEL_STRAND  = 6'd12;
   localparam logic [SW-1:0] SEL_LSU     = 6'd13;
   localparam logic [SW-1:0] SEL_PART    = 6'd14;
   localparam logic [SW-1:0] SEL_PCTX    = 6'd15;
   localparam logic [SW-1:0] SEL_SCTX    = 6'd16;
   localparam logic [SW-1:0] SEL_XLAT    = 6'd17;
   localparam logic [SW-1:0] SCR_BASE    = 6'd32;
   localparam logic [SW-1:0] QUE_BASE    = 6'd40;

   localparam int NSTK = 5;

   localparam logic [DW-1:0] PSTATE_KEEP = 64'h0000_0000_0000_0BDE;
   localparam logic [DW-1:0] TICK_RST    = 64'h8000_0000_0000_0000;
   localparam logic [DW-1:0] HPST_RST    = 64'h0000_0000_0000_0800;
   localparam logic [DW-1:0] STRAND_RST  = 64'h0000_0000_0005_0000;

   localparam int HP_TLZ   = 0;
   localparam int HP_HPRIV = 2;
   localparam int HP_RED   = 5;
   localparam int PS_PRIV  = 2;
   localparam int PS_AM    = 3;
endpackage

// File: rtl/priv_regarray.sv
module priv_regarray #(
   parameter int DEPTH = 8,
   parameter int DW    = 64,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [DW-1:0] rdata
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("priv_regarray: DEPTH must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = (int'(ridx) < DEPTH) ? mem[ridx] : '0;

   // R4: writes only ever reach a real entry
   p_widx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(widx) < DEPTH));
endmodule

// File: rtl/priv_xlat_pack.sv
module priv_xlat_pack #(
   parameter int CTX_W  = 16,
   parameter int PART_W = 8,
   parameter int TLW    = 3
) (
   input  logic              hpriv,
   input  logic              red,
   input  logic              priv,
   input  logic              am,
   input  logic [1:0]        lsu_bits,
   input  logic [PART_W-1:0] part,
   input  logic [TLW-1:0]    tl,
   input  logic [CTX_W-1:0]  pctx,
   input  logic [CTX_W-1:0]  sctx,
   output logic [63:0]       word
);
   if (CTX_W != 16 || PART_W != 8 || TLW != 3) begin : g_bad_fields
      $error("priv_xlat_pack: field widths fixed by the packed layout");
   end

   always_comb begin
      word        = '0;
      word[0]     = hpriv;
      word[1]     = red;
      word[2]     = priv;
      word[3]     = am;
      word[5:4]   = lsu_bits;
      word[15:8]  = part;
      word[18:16] = tl;
      word[47:32] = pctx;
      word[63:48] = sctx;
   end
endmodule

// File: rtl/priv_ctl_bank.sv
module priv_ctl_bank
   import priv_pkg::*;
#(
   parameter int MAX_TL    = 6,
   parameter int N_SCRATCH = 8,
   parameter int N_QUEUE   = 8,
   parameter int TBA_CLR   = 15,
   localparam int TLW      = 3,
   localparam int IW_T     = (MAX_TL > 1) ? $clog2(MAX_TL) : 1,
   localparam int IW_S     = (N_SCRATCH > 1) ? $clog2(N_SCRATCH) : 1,
   localparam int IW_Q     = (N_QUEUE > 1) ? $clog2(N_QUEUE) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [5:0]    wr_sel,
   input  logic [63:0]   wr_data,
   output logic          wr_err,
   input  logic [5:0]    rd_sel,
   input  logic          rd_fx,
   output logic [63:0]   rd_data,
   output logic          rd_err,
   output logic          tlz_irq,
   output logic [63:0]   xlat_word
);
   if (MAX_TL < 1 || MAX_TL > 7) begin : g_bad_tl
      $error("priv_ctl_bank: MAX_TL must fit the 3-bit level field");
   end
   if (N_SCRATCH < 1 || N_SCRATCH > 8 || N_QUEUE < 1 || N_QUEUE > 8) begin : g_bad_win
      $error("priv_ctl_bank: scratch and queue windows hold at most 8 codes");
   end
   if (TBA_CLR < 1 || TBA_CLR > 63) begin : g_bad_tba
      $error("priv_ctl_bank: TBA_CLR out of range");
   end

   localparam logic [DW-1:0] TBA_KEEP = ~((64'd1 << TBA_CLR) - 64'd1);
   localparam logic [TLW-1:0] TL_TOP  = TLW'(MAX_TL);

   logic [DW-1:0]  pstate_q, tba_q, hpstate_q, tick_q, strand_q, lsu_q;
   logic [TLW-1:0] tl_q;
   logic [3:0]     pil_q;
   logic [2:0]     fprs_q;
   logic [7:0]     part_q;
   logic [15:0]    pctx_q, sctx_q;
   logic           tlz_q;

   function automatic logic code_bad(input logic [SW-1:0] s, input logic tl_zero);
      logic bad;
      bad = 1'b1;
      if (s >= SCR_BASE && s < SCR_BASE + SW'(N_SCRATCH))     bad = 1'b0;
      else if (s >= QUE_BASE && s < QUE_BASE + SW'(N_QUEUE))  bad = 1'b0;
      else if (s >= SEL_TPC && s <= SEL_HTSTATE)              bad = tl_zero;
      else if (s <= SEL_XLAT)                                 bad = 1'b0;
      return bad;
   endfunction

   logic tl_zero, wr_ok;
   logic [TLW-1:0] tl_new;
   assign tl_zero = (tl_q == '0);
   assign wr_err  = wr_en & (code_bad(wr_sel, tl_zero) | (wr_sel == SEL_XLAT));
   assign wr_ok   = wr_en & ~wr_err;
   assign rd_err  = code_bad(rd_sel, tl_zero);
   assign tl_new  = (wr_data > 64'(MAX_TL)) ? TL_TOP : wr_data[TLW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pstate_q  <= '0;
         tl_q      <= '0;
         pil_q     <= '0;
         tba_q     <= '0;
         hpstate_q <= HPST_RST;
         tick_q    <= TICK_RST;
         fprs_q    <= '0;
         strand_q  <= STRAND_RST;
         lsu_q     <= '0;
         part_q    <= '0;
         pctx_q    <= '0;
         sctx_q    <= '0;
         tlz_q     <= 1'b0;
      end else if (wr_ok) begin
         case (wr_sel)
            SEL_PSTATE:  pstate_q  <= wr_data & PSTATE_KEEP;
            SEL_TL: begin
               tl_q  <= tl_new;
               tlz_q <= hpstate_q[HP_TLZ] && !hpstate_q[HP_HPRIV] && (tl_new == '0);
            end
            SEL_PIL:     pil_q     <= wr_data[3:0];
            SEL_TBA:     tba_q     <= wr_data & TBA_KEEP;
            SEL_HPSTATE: hpstate_q <= wr_data;
            SEL_TICK:    tick_q    <= wr_data;
            SEL_FPRS:    fprs_q    <= wr_data[2:0];
            SEL_STRAND:  strand_q  <= wr_data;
            SEL_LSU:     lsu_q     <= wr_data;
            SEL_PART:    part_q    <= wr_data[7:0];
            SEL_PCTX:    pctx_q    <= wr_data[15:0];
            SEL_SCTX:    sctx_q    <= wr_data[15:0];
            default: ;
         endcase
      end
   end
   assign tlz_irq = tlz_q;

   // trap-save stacks, one array per kind, all indexed by TL-1
   logic [IW_T-1:0] tl_idx;
   logic [DW-1:0]   ts_rd [NSTK];
   assign tl_idx = IW_T'(tl_q - TLW'(1));

   for (genvar k = 0; k < NSTK; k++) begin : g_stk
      priv_regarray #(.DEPTH(MAX_TL), .DW(DW)) u_stk (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_ok && (wr_sel == SEL_TPC + SW'(k))),
         .widx  (tl_idx),
         .wdata (wr_data),
         .ridx  (tl_idx),
         .rdata (ts_rd[k])
      );
   end

   logic [DW-1:0] scr_rd, que_rd;
   logic scr_we, que_we;
   assign scr_we = wr_ok && wr_sel >= SCR_BASE && wr_sel < SCR_BASE + SW'(N_SCRATCH);
   assign que_we = wr_ok && wr_sel >= QUE_BASE && wr_sel < QUE_BASE + SW'(N_QUEUE);

   priv_regarray #(.DEPTH(N_SCRATCH), .DW(DW)) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (scr_we),
      .widx  (IW_S'(wr_sel - SCR_BASE)),
      .wdata (wr_data),
      .ridx  (IW_S'(rd_sel - SCR_BASE)),
      .rdata (scr_rd)
   );

   priv_regarray #(.DEPTH(N_QUEUE), .DW(DW)) u_que (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (que_we),
      .widx  (IW_Q'(wr_sel - QUE_BASE)),
      .wdata (wr_data),
      .ridx  (IW_Q'(rd_sel - QUE_BASE)),
      .rdata (que_rd)
   );

   priv_xlat_pack u_xlat (
      .hpriv    (hpstate_q[HP_HPRIV]),
      .red      (hpstate_q[HP_RED]),
      .priv     (pstate_q[PS_PRIV]),
      .am       (pstate_q[PS_AM]),
      .lsu_bits (lsu_q[3:2]),
      .part     (part_q),
      .tl       (tl_q),
      .pctx     (pctx_q),
      .sctx     (sctx_q),
      .word     (xlat_word)
   );

   always_comb begin
      rd_data = '0;
      if (!rd_err) begin
         if (rd_sel >= SCR_BASE && rd_sel < SCR_BASE + SW'(N_SCRATCH))
            rd_data = scr_rd;
         else if (rd_sel >= QUE_BASE && rd_sel < QUE_BASE + SW'(N_QUEUE))
            rd_data = que_rd;
         else if (rd_sel >= SEL_TPC && rd_sel <= SEL_HTSTATE)
            rd_data = ts_rd[3'(rd_sel - SEL_TPC)];
         else begin
            case (rd_sel)
               SEL_PSTATE:  rd_data = pstate_q;
               SEL_TL:      rd_data = 64'(tl_q);
               SEL_PIL:     rd_data = 64'(pil_q);
               SEL_TBA:     rd_data = tba_q;
               SEL_HPSTATE: rd_data = hpstate_q;
               SEL_TICK:    rd_data = tick_q;
               SEL_FPRS:    rd_data = 64'(fprs_q | (rd_fx ? 3'b011 : 3'b000));
               SEL_STRAND:  rd_data = strand_q;
               SEL_LSU:     rd_data = lsu_q;
               SEL_PART:    rd_data = 64'(part_q);
               SEL_PCTX:    rd_data = 64'(pctx_q);
               SEL_SCTX:    rd_data = 64'(sctx_q);
               SEL_XLAT:    rd_data = xlat_word;
               default:     rd_data = '0;
            endcase
         end
      end
   end

   // R6: only a trap-level write may move the request
   p_tlz_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_TL) |=> $stable(tlz_irq));
   // R6: all enabling conditions met raises the request
   p_tlz_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_TL && wr_data == '0 &&
       hpstate_q[HP_TLZ] && !hpstate_q[HP_HPRIV]) |=> tlz_irq);
   // R10: rejected reads return zero
   p_err_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (rd_data == '0));
   // R7: dirty bits visible on a read with effects
   p_fprs_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_FPRS && rd_fx) |-> (rd_data[1:0] == 2'b11));
   // R2: undefined processor-state bits never read back
   p_pstate_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_PSTATE) |-> ((rd_data & ~PSTATE_KEEP) == '0));
   // R11: stack access at level zero is rejected
   p_stack_tl0_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tl_q == '0 && wr_sel == SEL_TPC) |-> wr_err);
endmodule

// File: tb/sim_priv_ctl_bank.sv
`timescale 1ns/1ps
module sim_priv_ctl_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_sel = '0;
   logic [63:0] wr_data = '0;
   logic        wr_err;
   logic [5:0]  rd_sel = '0;
   logic        rd_fx = 1'b0;
   logic [63:0] rd_data;
   logic        rd_err;
   logic        tlz_irq;
   logic [63:0] xlat_word;

   always #2.5 clk = ~clk;

   priv_ctl_bank u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .wr_err(wr_err), .rd_sel(rd_sel), .rd_fx(rd_fx),
      .rd_data(rd_data), .rd_err(rd_err), .tlz_irq(tlz_irq), .xlat_word(xlat_word)
   );

   typedef struct packed {
      logic [23:0] tag;
      logic        wr;
      logic        fx;
      logic [5:0]  sel;
      logic [63:0] dat;
      logic        err;
   } vec_t;

   localparam int NV = 40;
   localparam vec_t VEC [NV] = '{
      '{"R1",  1'b0, 1'b0, 6'd10, 64'h8000_0000_0000_0000, 1'b0},
      '{"R1",  1'b0, 1'b0, 6'd9,  64'h0000_0000_0000_0800, 1'b0},
      '{"R1",  1'b0, 1'b0, 6'd12, 64'h0000_0000_0005_0000, 1'b0},
      '{"R1",  1'b0, 1'b0, 6'd3,  64'h0,                   1'b0},
      '{"R2",  1'b1, 1'b0, 6'd0,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
      '{"R2",  1'b0, 1'b0, 6'd0,  64'h0000_0000_0000_0BDE, 1'b0},
      '{"R3",  1'b1, 1'b0, 6'd3,  64'h1234_5678_9ABC_DEFF, 1'b0},
      '{"R3",  1'b0, 1'b0, 6'd3,  64'h1234_5678_9ABC_8000, 1'b0},
      '{"R7",  1'b1, 1'b0, 6'd11, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0},
      '{"R7",  1'b0, 1'b0, 6'd11, 64'h4,                   1'b0},
      '{"R7",  1'b0, 1'b1, 6'd11, 64'h7,                   1'b0},
      '{"R9",  1'b1, 1'b0, 6'd35, 64'hA5A5_5A5A_0F0F_F0F0, 1'b0},
      '{"R9",  1'b0, 1'b0, 6'd35, 64'hA5A5_5A5A_0F0F_F0F0, 1'b0},
      '{"R9",  1'b0, 1'b0, 6'd34, 64'h0,                   1'b0},
      '{"R9",  1'b1, 1'b0, 6'd45, 64'hDEAD_BEEF_0000_0001, 1'b0},
      '{"R9",  1'b0, 1'b0, 6'd45, 64'hDEAD_BEEF_0000_0001, 1'b0},
      '{"R9",  1'b0, 1'b0, 6'd44, 64'h0,                   1'b0},
      '{"R10", 1'b0, 1'b0, 6'd18, 64'h0,                   1'b1},
      '{"R10", 1'b1, 1'b0, 6'd19, 64'h5,                   1'b1},
      '{"R10", 1'b1, 1'b0, 6'd50, 64'hFFFF,                1'b1},
      '{"R10", 1'b0, 1'b0, 6'd0,  64'h0000_0000_0000_0BDE, 1'b0},
      '{"R10", 1'b0, 1'b0, 6'd50, 64'h0,                   1'b1},
      '{"R11", 1'b1, 1'b0, 6'd4,  64'hBAD0,                1'b1},
      '{"R11", 1'b0, 1'b0, 6'd4,  64'h0,                   1'b1},
      '{"R5",  1'b1, 1'b0, 6'd1,  64'h9,                   1'b0},
      '{"R5",  1'b0, 1'b0, 6'd1,  64'h6,                   1'b0},
      '{"R4",  1'b1, 1'b0, 6'd4,  64'h6666,                1'b0},
      '{"R4",  1'b1, 1'b0, 6'd1,  64'h2,                   1'b0},
      '{"R4",  1'b1, 1'b0, 6'd4,  64'h2222,                1'b0},
      '{"R4",  1'b1, 1'b0, 6'd7,  64'h22,                  1'b0},
      '{"R4",  1'b1, 1'b0, 6'd1,  64'h1,                   1'b0},
      '{"R11", 1'b0, 1'b0, 6'd4,  64'h0,                   1'b0},
      '{"R4",  1'b1, 1'b0, 6'd4,  64'h1111,                1'b0},
      '{"R4",  1'b0, 1'b0, 6'd4,  64'h1111,                1'b0},
      '{"R4",  1'b0, 1'b0, 6'd7,  64'h0,                   1'b0},
      '{"R4",  1'b1, 1'b0, 6'd1,  64'h2,                   1'b0},
      '{"R4",  1'b0, 1'b0, 6'd4,  64'h2222,                1'b0},
      '{"R4",  1'b0, 1'b0, 6'd7,  64'h22,                  1'b0},
      '{"R4",  1'b1, 1'b0, 6'd1,  64'h6,                   1'b0},
      '{"R4",  1'b0, 1'b0, 6'd4,  64'h6666,                1'b0}
   };

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got 0x%016h expected 0x%016h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] s, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] s, input logic fx);
      @(negedge clk);
      rd_sel = s; rd_fx = fx;
      #1;
   endtask

   task automatic apply(input vec_t v);
      string t;
      t = $sformatf("%s", v.tag);
      @(negedge clk);
      if (v.wr) begin
         wr_en = 1'b1; wr_sel = v.sel; wr_data = v.dat;
         #1;
         chk({t, " wr_err"}, 64'(wr_err), 64'(v.err));
         @(negedge clk);
         wr_en = 1'b0;
      end else begin
         rd_sel = v.sel; rd_fx = v.fx;
         #1;
         chk({t, " rd_data"}, rd_data, v.dat);
         chk({t, " rd_err"}, 64'(rd_err), 64'(v.err));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: outputs at reset
      chk("R1 tlz_irq", 64'(tlz_irq), 64'h0);
      chk("R1 xlat_word", xlat_word, 64'h0);

      for (int i = 0; i < NV; i++) apply(VEC[i]);

      // R6: request raised with tlz set, hpriv clear, level 0
      wr(6'd9, 64'h801);
      wr(6'd1, 64'h0);
      chk("R6 raise", 64'(tlz_irq), 64'h1);
      wr(6'd2, 64'hF);
      chk("R6 other write keeps", 64'(tlz_irq), 64'h1);
      wr(6'd1, 64'h1);
      chk("R6 nonzero level clears", 64'(tlz_irq), 64'h0);
      wr(6'd9, 64'h805);
      wr(6'd1, 64'h0);
      chk("R6 hpriv blocks", 64'(tlz_irq), 64'h0);
      wr(6'd9, 64'h800);
      wr(6'd1, 64'h0);
      chk("R6 tlz off blocks", 64'(tlz_irq), 64'h0);

      // R8: packed translation word
      wr(6'd9,  64'h024);
      wr(6'd0,  64'h00C);
      wr(6'd13, 64'hC);
      wr(6'd14, 64'h1AB);
      wr(6'd1,  64'h3);
      wr(6'd15, 64'h5_1234);
      wr(6'd16, 64'hBEEF);
      @(negedge clk);
      chk("R8 xlat_word", xlat_word, 64'hBEEF_1234_0003_AB3F);
      rd(6'd17, 1'b0);
      chk("R8 read code 17", rd_data, 64'hBEEF_1234_0003_AB3F);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 6'd17; wr_data = 64'h0;
      #1;
      chk("R10 write code 17", 64'(wr_err), 64'h1);
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10 xlat unchanged", xlat_word, 64'hBEEF_1234_0003_AB3F);

      // R1: reset again clears written state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(6'd35, 1'b0);
      chk("R1 scratch cleared", rd_data, 64'h0);
      rd(6'd10, 1'b0);
      chk("R1 tick reset", rd_data, 64'h8000_0000_0000_0000);
      rd(6'd1, 1'b0);
      chk("R1 tl reset", rd_data, 64'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: got 0x%016h expected 0x%016h", 64'h0, 64'h1);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule